// File: doc/BRIEF.md
# Descriptor Chain Sequencer

This block runs one channel of a scatter/gather copy unit. Software programs the first node's link, count, source, destination and configuration directly on the programming inputs. It then pulses the start input, and the configuration's enable bit must be set for the pulse to take effect. The block places those values in the channel's working registers and tells the transfer engine to begin. When the engine reports the node finished, the block checks the node's link word. If the word asks to continue, the block reads the next 32-byte node from memory and hands it to the engine. This repeats until a node whose link does not continue has completed.

Each node in memory is 32 bytes on a 32-byte boundary. The link word sits at byte offset 0, and offsets 4 to 12 are spare and never read. Count, source, destination and configuration sit at offsets 16, 20, 24 and 28. A node may ask for an event when it completes. A separate event marks the end of the chain, and the busy flag drops at that moment. A link that points back to an earlier node gives a ring that runs until reset, raising node events as it goes. The current-link output always shows the link word of the node now loaded. Software can use it to work out how much work remains.

Top module: `dll_chain_loader`

## Requirements
- R1: After reset, busy, xfer_go, mem_req, node_evt and chain_evt are all 0 and cur_link is 0.
- R2: A start pulse seen while idle with configuration bit 0 set loads the five programmed values into the working registers. In the next cycle busy is 1 and xfer_go is high for exactly one cycle, carrying the programmed count, source, destination and configuration.
- R3: A start pulse with configuration bit 0 clear, or a start pulse while busy, has no effect on any output.
- R4: After xfer_done, if bit 1 of the current link word is set, the block issues five single-cycle reads, one at a time, each waiting for mem_rvalid. The base address is the link word with bits 4..0 forced to zero, and the reads go to base+0, +16, +20, +24 and +28 in that order.
- R5: Read data lands in link, count, source, destination and configuration for offsets 0, 16, 20, 24 and 28. The cycle after the fifth response, xfer_go pulses with the new values.
- R6: No read is issued between an xfer_go pulse and the matching xfer_done.
- R7: In the cycle after xfer_done, node_evt pulses for one cycle if bit 1 of the finished node's configuration is set.
- R8: If bit 1 of the finished node's link word is clear (a zero link included), chain_evt pulses for one cycle after xfer_done and busy is 0 in that same cycle.
- R9: On every xfer_go, cur_link equals the link word of the node being handed over.
- R10: A chain whose last link points back to its first node runs without end: busy stays 1 and the nodes repeat in ring order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse from the register side |
| prg_link | input | DW | First node link word |
| prg_count | input | DW | First node byte count |
| prg_src | input | DW | First node source address |
| prg_dst | input | DW | First node destination address |
| prg_cfg | input | DW | First node configuration (bit 0 enable, bit 1 node event) |
| mem_req | output | 1 | Single-cycle descriptor read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| xfer_go | output | 1 | One-cycle pulse: working registers hold a node ready to run |
| xfer_count | output | DW | Working count |
| xfer_src | output | DW | Working source address |
| xfer_dst | output | DW | Working destination address |
| xfer_cfg | output | DW | Working configuration |
| xfer_done | input | 1 | Transfer engine finished the current node |
| cur_link | output | DW | Link word of the node now loaded |
| busy | output | 1 | Channel active |
| node_evt | output | 1 | Per-node completion event |
| chain_evt | output | 1 | Chain-complete event |

## Verification
The sequencer is driven with four chain shapes. The first is a lone node with a zero link, which isolates the start path and the end-of-chain event. The second is a three-node chain whose middle link has its low bits dirty and whose event bits vary, so address masking, word order and the per-node event choice are each exposed. The third is a chain ending on a nonzero link with bit 1 clear, which separates "zero ends the chain" from "continue bit clear ends the chain". The last is a two-node ring run for five hand-overs, which shows that a back-pointing link keeps the channel busy and revisits nodes in order. Start pulses with the enable bit clear, and start pulses while the chain is running, check that neither disturbs the expected stream.

// File: rtl/dll_pkg.sv
package dll_pkg;
   localparam int DLL_NF    = 5;   // link, count, source, destination, configuration
   localparam int DLL_SEL_W = 3;
   localparam int DLL_ALB   = 5;   // node alignment bits (32-byte nodes)

   localparam int F_LINK = 0;
   localparam int F_CNT  = 1;
   localparam int F_SRC  = 2;
   localparam int F_DST  = 3;
   localparam int F_CFG  = 4;

   typedef enum logic [2:0] {
      S_IDLE,
      S_GO,
      S_WAIT,
      S_FETCH,
      S_RESP
   } dll_state_e;

   // byte offset inside a node for fetch slot i: 0, 16, 20, 24, 28
   function automatic logic [DLL_ALB-1:0] word_off(input logic [DLL_SEL_W-1:0] i);
      logic [DLL_SEL_W-1:0] w;
      w = i + 3'd3;
      return (i == '0) ? '0 : {w, 2'b00};
   endfunction
endpackage

// File: rtl/dll_fields.sv
module dll_fields
   import dll_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_all,
   input  logic [DW-1:0]        prg [DLL_NF],
   input  logic                 ld_one,
   input  logic [DLL_SEL_W-1:0] ld_sel,
   input  logic [DW-1:0]        ld_data,
   output logic [DW-1:0]        fld [DLL_NF]
);
   for (genvar g = 0; g < DLL_NF; g++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fld[g] <= '0;
         end else if (ld_all) begin
            fld[g] <= prg[g];
         end else if (ld_one && ld_sel == DLL_SEL_W'(g)) begin
            fld[g] <= ld_data;
         end
      end
   end
endmodule

// File: rtl/dll_seq.sv
module dll_seq
   import dll_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 start_en,
   input  logic                 link_cont,
   input  logic [AW-1:DLL_ALB]  link_base,
   input  logic                 node_irq,
   input  logic                 mem_rvalid,
   input  logic                 xfer_done,
   output logic                 mem_req,
   output logic [AW-1:0]        mem_addr,
   output logic                 xfer_go,
   output logic                 busy,
   output logic                 node_evt,
   output logic                 chain_evt,
   output logic                 ld_all,
   output logic                 ld_one,
   output logic [DLL_SEL_W-1:0] ld_sel
);
   localparam logic [DLL_SEL_W-1:0] LAST_SLOT = DLL_SEL_W'(DLL_NF - 1);

   dll_state_e              st_q;
   logic [AW-1:DLL_ALB]     base_q;
   logic [DLL_SEL_W-1:0]    idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         base_q    <= '0;
         idx_q     <= '0;
         node_evt  <= 1'b0;
         chain_evt <= 1'b0;
      end else begin
         node_evt  <= 1'b0;
         chain_evt <= 1'b0;
         case (st_q)
            S_IDLE:  if (start && start_en) st_q <= S_GO;
            S_GO:    st_q <= S_WAIT;
            S_WAIT: begin
               if (xfer_done) begin
                  node_evt <= node_irq;
                  if (link_cont) begin
                     base_q <= link_base;
                     idx_q  <= '0;
                     st_q   <= S_FETCH;
                  end else begin
                     chain_evt <= 1'b1;
                     st_q      <= S_IDLE;
                  end
               end
            end
            S_FETCH: st_q <= S_RESP;
            S_RESP: begin
               if (mem_rvalid) begin
                  if (idx_q == LAST_SLOT) begin
                     st_q <= S_GO;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= S_FETCH;
                  end
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = (st_q == S_FETCH);
      mem_addr = {base_q, word_off(idx_q)};
      xfer_go  = (st_q == S_GO);
      busy     = (st_q != S_IDLE);
      ld_all   = (st_q == S_IDLE) && start && start_en;
      ld_one   = (st_q == S_RESP) && mem_rvalid;
      ld_sel   = idx_q;
   end
endmodule

// File: rtl/dll_chain_loader.sv
module dll_chain_loader
   import dll_pkg::*;
#(
   parameter int AW           = 32,
   parameter int DW           = 32,
   parameter int EN_BIT       = 0,
   parameter int NODE_EVT_BIT = 1,
   parameter int CHAIN_BIT    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] prg_link,
   input  logic [DW-1:0] prg_count,
   input  logic [DW-1:0] prg_src,
   input  logic [DW-1:0] prg_dst,
   input  logic [DW-1:0] prg_cfg,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata,
   output logic          xfer_go,
   output logic [DW-1:0] xfer_count,
   output logic [DW-1:0] xfer_src,
   output logic [DW-1:0] xfer_dst,
   output logic [DW-1:0] xfer_cfg,
   input  logic          xfer_done,
   output logic [DW-1:0] cur_link,
   output logic          busy,
   output logic          node_evt,
   output logic          chain_evt
);
   if (AW <= DLL_ALB) begin : g_bad_aw
      $error("AW must exceed the node alignment bits");
   end
   if (DW < AW) begin : g_bad_dw
      $error("DW must hold a full address");
   end
   if (EN_BIT >= DW || NODE_EVT_BIT >= DW || CHAIN_BIT >= DLL_ALB) begin : g_bad_bits
      $error("control bit positions out of range");
   end

   logic [DW-1:0]        prg [DLL_NF];
   logic [DW-1:0]        fld [DLL_NF];
   logic                 ld_all, ld_one;
   logic [DLL_SEL_W-1:0] ld_sel;

   assign prg[F_LINK] = prg_link;
   assign prg[F_CNT]  = prg_count;
   assign prg[F_SRC]  = prg_src;
   assign prg[F_DST]  = prg_dst;
   assign prg[F_CFG]  = prg_cfg;

   dll_fields #(.DW(DW)) u_fields (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_all  (ld_all),
      .prg     (prg),
      .ld_one  (ld_one),
      .ld_sel  (ld_sel),
      .ld_data (mem_rdata),
      .fld     (fld)
   );

   dll_seq #(.AW(AW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_en   (prg_cfg[EN_BIT]),
      .link_cont  (fld[F_LINK][CHAIN_BIT]),
      .link_base  (fld[F_LINK][AW-1:DLL_ALB]),
      .node_irq   (fld[F_CFG][NODE_EVT_BIT]),
      .mem_rvalid (mem_rvalid),
      .xfer_done  (xfer_done),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .xfer_go    (xfer_go),
      .busy       (busy),
      .node_evt   (node_evt),
      .chain_evt  (chain_evt),
      .ld_all     (ld_all),
      .ld_one     (ld_one),
      .ld_sel     (ld_sel)
   );

   assign cur_link   = fld[F_LINK];
   assign xfer_count = fld[F_CNT];
   assign xfer_src   = fld[F_SRC];
   assign xfer_dst   = fld[F_DST];
   assign xfer_cfg   = fld[F_CFG];
endmodule

// File: rtl/dll_chain_loader_chk.sv
module dll_chain_loader_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [DW-1:0] prg_link,
   input logic [DW-1:0] prg_count,
   input logic [DW-1:0] prg_src,
   input logic [DW-1:0] prg_dst,
   input logic [DW-1:0] prg_cfg,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_rvalid,
   input logic [DW-1:0] mem_rdata,
   input logic          xfer_go,
   input logic [DW-1:0] xfer_count,
   input logic [DW-1:0] xfer_src,
   input logic [DW-1:0] xfer_dst,
   input logic [DW-1:0] xfer_cfg,
   input logic          xfer_done,
   input logic [DW-1:0] cur_link,
   input logic          busy,
   input logic          node_evt,
   input logic          chain_evt
);
   logic in_xfer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         in_xfer <= 1'b0;
      else if (xfer_go)   in_xfer <= 1'b1;
      else if (xfer_done) in_xfer <= 1'b0;
   end

   p_go_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go |=> !xfer_go);

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !xfer_go));

   p_req_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[4:0] == 5'd0  || mem_addr[4:0] == 5'd16 ||
                   mem_addr[4:0] == 5'd20 || mem_addr[4:0] == 5'd24 ||
                   mem_addr[4:0] == 5'd28));

   p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   p_no_fetch_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !in_xfer);

   p_node_evt_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      node_evt |=> !node_evt);

   p_chain_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chain_evt |-> !busy);

   p_link_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_xfer && !xfer_go) |-> $stable(cur_link));
endmodule

bind dll_chain_loader dll_chain_loader_chk #(.AW(AW), .DW(DW)) i_chk (.*);

// File: tb/test_dll_chain_loader.sv
module test_dll_chain_loader;
   typedef struct packed {
      logic [31:0] link;
      logic [31:0] count;
      logic [31:0] src;
      logic [31:0] dst;
      logic [31:0] cfg;
   } node_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] prg_link = '0, prg_count = '0, prg_src = '0, prg_dst = '0, prg_cfg = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        xfer_go;
   logic [31:0] xfer_count, xfer_src, xfer_dst, xfer_cfg;
   logic        xfer_done = 1'b0;
   logic [31:0] cur_link;
   logic        busy, node_evt, chain_evt;

   always #2.5 clk = ~clk;   // 200 MHz

   dll_chain_loader i_dll_chain_loader (.*);

   logic [31:0] mem [64];
   node_t       exp_go [$];
   logic [31:0] exp_rd [$];
   logic [1:0]  exp_ev [$];
   int          checks = 0, errors = 0, go_seen = 0;
   int          mcnt = 0, ecnt = 0;
   logic [31:0] maddr;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: response two cycles after the request
   always @(negedge clk) begin
      mem_rvalid = 1'b0;
      if (!rst_n) mcnt = 0;
      else begin
         if (mcnt > 0) begin
            mcnt--;
            if (mcnt == 0) begin
               mem_rdata  = mem[maddr[7:2]];
               mem_rvalid = 1'b1;
            end
         end
         if (mem_req) begin
            maddr = mem_addr;
            mcnt  = 2;
         end
      end
   end

   // transfer engine model: done three cycles after go
   always @(negedge clk) begin
      xfer_done = 1'b0;
      if (!rst_n) ecnt = 0;
      else begin
         if (ecnt > 0) begin
            ecnt--;
            if (ecnt == 0) xfer_done = 1'b1;
         end
         if (xfer_go) ecnt = 3;
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req) begin
            if (exp_rd.size() == 0) chk(1'b0, "R4 unexpected read", mem_addr, 32'h0);
            else begin
               logic [31:0] ea;
               ea = exp_rd.pop_front();
               chk(mem_addr == ea, "R4 read address", mem_addr, ea);
            end
         end
         if (xfer_go) begin
            go_seen++;
            if (exp_go.size() == 0) chk(1'b0, "R3 unexpected xfer_go", xfer_count, 32'h0);
            else begin
               node_t en;
               en = exp_go.pop_front();
               chk(xfer_count == en.count, "R5 count", xfer_count, en.count);
               chk(xfer_src   == en.src,   "R5 source", xfer_src, en.src);
               chk(xfer_dst   == en.dst,   "R5 destination", xfer_dst, en.dst);
               chk(xfer_cfg   == en.cfg,   "R5 configuration", xfer_cfg, en.cfg);
               chk(cur_link   == en.link,  "R9 cur_link", cur_link, en.link);
            end
         end
         if (node_evt || chain_evt) begin
            if (exp_ev.size() == 0) chk(1'b0, "R7 unexpected event", {30'd0, chain_evt, node_evt}, 32'h0);
            else begin
               logic [1:0] ee;
               ee = exp_ev.pop_front();
               chk({chain_evt, node_evt} == ee, "R7/R8 event pair", {30'd0, chain_evt, node_evt}, {30'd0, ee});
            end
            if (chain_evt) chk(busy == 1'b0, "R8 busy low with chain_evt", {31'd0, busy}, 32'h0);
         end
      end
   end

   task automatic put_node(input int a, input logic [31:0] l, c, s, d, f);
      mem[a/4]     = l;
      mem[a/4 + 1] = 32'hBAD0_0000 | a;
      mem[a/4 + 2] = 32'hBAD1_0000 | a;
      mem[a/4 + 3] = 32'hBAD2_0000 | a;
      mem[a/4 + 4] = c;
      mem[a/4 + 5] = s;
      mem[a/4 + 6] = d;
      mem[a/4 + 7] = f;
   endtask

   // driver: predicts the stream from the requirements, then pulses start
   task automatic run_chain(input node_t first, input int limit, input bit ring);
      node_t cur;
      cur = first;
      for (int n = 0; n < limit; n++) begin
         logic [31:0] b;
         exp_go.push_back(cur);
         if (ring && n == limit - 1) break;
         if (cur.cfg[1] || !cur.link[1]) exp_ev.push_back({!cur.link[1], cur.cfg[1]});
         if (!cur.link[1]) break;
         b = cur.link & ~32'h1F;
         exp_rd.push_back(b);
         for (int k = 16; k <= 28; k += 4) exp_rd.push_back(b + k);
         cur = '{mem[b[7:2]], mem[b[7:2] + 4], mem[b[7:2] + 5], mem[b[7:2] + 6], mem[b[7:2] + 7]};
      end
      @(negedge clk);
      prg_link = first.link; prg_count = first.count; prg_src = first.src;
      prg_dst = first.dst; prg_cfg = first.cfg;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", {31'd0, busy}, 32'h1);
      chk(xfer_go == 1'b1, "R2 xfer_go cycle after start", {31'd0, xfer_go}, 32'h1);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(exp_go.size() == 0, "R5 all nodes handed over", exp_go.size(), 32'h0);
      chk(exp_rd.size() == 0, "R4 all reads seen", exp_rd.size(), 32'h0);
      chk(exp_ev.size() == 0, "R7 all events seen", exp_ev.size(), 32'h0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int g0;
      for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | i;
      put_node(32'h20, 32'h0000_0043, 32'h1FFC, 32'h11000, 32'h21000, 32'h1);
      put_node(32'h40, 32'h0,         32'h10,   32'h12000, 32'h22000, 32'h3);
      put_node(32'h60, 32'h0000_0080, 32'h20,   32'h13000, 32'h23000, 32'h3);
      put_node(32'hA0, 32'h0000_00C2, 32'h40,   32'h14000, 32'h24000, 32'h3);
      put_node(32'hC0, 32'h0000_00A2, 32'h80,   32'h15000, 32'h25000, 32'h3);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(busy == 1'b0,      "R1 busy",      {31'd0, busy},      32'h0);
      chk(xfer_go == 1'b0,   "R1 xfer_go",   {31'd0, xfer_go},   32'h0);
      chk(mem_req == 1'b0,   "R1 mem_req",   {31'd0, mem_req},   32'h0);
      chk({node_evt, chain_evt} == 2'b00, "R1 events", {30'd0, node_evt, chain_evt}, 32'h0);
      chk(cur_link == 32'h0, "R1 cur_link",  cur_link,           32'h0);

      // R3: start with enable bit clear is ignored
      @(negedge clk);
      prg_link = 32'h22; prg_count = 32'h5; prg_cfg = 32'h2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (8) @(negedge clk);
      chk(busy == 1'b0, "R3 disabled start leaves idle", {31'd0, busy}, 32'h0);
      chk(go_seen == 0, "R3 disabled start gives no xfer_go", go_seen, 32'h0);
      chk(cur_link == 32'h0, "R3 disabled start loads nothing", cur_link, 32'h0);

      // single node with zero link (R2, R8)
      run_chain('{32'h0, 32'h100, 32'h1000, 32'h2000, 32'h1}, 16, 1'b0);
      wait_idle();

      // three nodes, masked link, mixed event bits (R4, R5, R7, R9) plus start while busy (R3)
      fork
         run_chain('{32'h22, 32'h100, 32'h10000, 32'h20000, 32'h3}, 16, 1'b0);
         begin
            repeat (4) @(negedge clk);
            prg_src = 32'hFFFF_0000; prg_count = 32'h7; prg_cfg = 32'h3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      join
      wait_idle();

      // nonzero link with continue bit clear ends the chain (R8)
      run_chain('{32'h62, 32'h30, 32'h16000, 32'h26000, 32'h1}, 16, 1'b0);
      wait_idle();

      // ring of two nodes (R10)
      g0 = go_seen;
      run_chain('{32'hC2, 32'h40, 32'h14000, 32'h24000, 32'h3}, 5, 1'b1);
      while (go_seen < g0 + 5) @(negedge clk);
      chk(busy == 1'b1, "R10 ring still busy", {31'd0, busy}, 32'h1);
      chk(exp_go.size() == 0 && exp_rd.size() == 0, "R10 ring order",
          exp_go.size() + exp_rd.size(), 32'h0);
      chk(exp_ev.size() == 0, "R10 ring node events", exp_ev.size(), 32'h0);
      do_reset();
      chk(busy == 1'b0, "R1 busy after reset in ring", {31'd0, busy}, 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule